// File: doc/BRIEF.md
# Power-of-Two Step LMS Echo Canceller

This block removes the echo of the locally received signal from the line signal with an adaptive FIR filter of `N_TAPS` coefficients. One sample pair is handled at a time. The pair is the received sample, which is the far-end reference, and the line sample, which is the transmit signal with echo added. The datapath then steps through the coefficient index from 0 to `N_TAPS-1`, one index per clock.

At each index the coefficient is corrected first, using the error of the previous sample and the received sample that was one sample older than the one the tap now sees. The corrected value then multiplies the current tap sample and is added to the echo estimate. After the last index, the block presents the residual: the line sample minus the echo estimate, clipped to the sample width. The same residual is kept for the next round of corrections.

The adaptation gain is a power of two, 2^-s. A 4-bit code selects it, and it is applied by an arithmetic right shift of the error-times-sample product. Code 0 halts adaptation entirely. Coefficients carry `FRAC` fractional bits, so the echo estimate is the accumulated sum shifted right by `FRAC`.

Top module: `lms_echo_canceller`

## Requirements
- R1: After reset, `smp_ready` is 1 and `err_valid` is 0. Coefficients, the tap history and the stored previous error are all zero, so the first residual equals the line sample.
- R2: A sample pair is taken only on a clock edge where `smp_valid` and `smp_ready` are both 1. `smp_ready` stays 0 from acceptance until the residual has been taken, and `smp_valid` pulses during that time are ignored.
- R3: `err_valid` rises exactly `N_TAPS` clock cycles after the acceptance edge.
- R4: While `err_valid` is 1 and `err_ready` is 0, `err_valid` stays 1 and `err_data` does not change. The residual is taken on an edge where both are 1.
- R5: The residual is e(n) = sat(d(n) − ((Σk h(n,k)·r(n−k)) >>> FRAC)), where r(n) is `smp_rx`, d(n) is `smp_tx` and h(n,k) is the coefficient already corrected during the same pass.
- R6: The correction is h(n,k) = h(n−1,k) + ((e(n−1)·r(n−1−k)) >>> s). Here e(n−1) is the stored clipped previous residual and the coefficient wraps at `CW` bits.
- R7: A `mu_shift` code s from 1 to 15 gives an arithmetic right shift of exactly s bits on the signed 2·`DW`-bit product.
- R8: `mu_shift` = 0 makes the correction zero, so every coefficient keeps its value.
- R9: `mu_shift` is captured at acceptance. Changes on the pin during the coefficient walk do not affect that sample.
- R10: The residual is clipped to [−32768, 32767] for `DW`=16 before it is output and before it is stored.
- R11: The tap history shifts by one per accepted sample. The newest sample becomes tap 0 of the next sample's corrections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Block can take a sample pair |
| smp_rx | input | DW | Received (reference) sample, signed |
| smp_tx | input | DW | Line sample with echo, signed |
| mu_shift | input | 4 | Step-size shift code, 0 halts adaptation |
| err_valid | output | 1 | Residual available |
| err_ready | input | 1 | Consumer takes the residual |
| err_data | output | DW | Echo-free residual, signed, clipped |

## Verification
The bench targets the ordering inside one pass. A design that used the coefficient before correcting it, or that paired the correction with the current tap sample rather than the one-older sample, would drift away from the reference model within a few adapting samples. Large-signal pairs drive the residual past both rails. A design that wrapped instead of clipping, or that stored the unclipped value, would show the wrong sign on the next outputs. Further tests cover a halt code repeating identical residuals, a step code changed mid-walk, and offers made under output backpressure. These catch a design that reads the live pin, one that accepts while busy, and one whose output moves while it is stalled.

// File: rtl/ec_pkg.sv
package ec_pkg;
    localparam int SHIFT_CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } ec_state_e;
endpackage

// File: rtl/ec_step_shift.sv
// Logarithmic arithmetic right shifter: stage i shifts by 2**i when code bit i is set.
// A code of zero forces the result to zero (adaptation halted).
module ec_step_shift #(
    parameter int IW = 32,
    parameter int OW = 32,
    parameter int SW = 4
) (
    input  logic signed [IW-1:0] din,
    input  logic        [SW-1:0] code,
    output logic signed [OW-1:0] dout
);
    logic signed [IW-1:0] stg [SW+1];
    logic signed [OW-1:0] ext;

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        assign stg[i+1] = code[i] ? (stg[i] >>> (1 << i)) : stg[i];
    end

    if (OW > IW) begin : g_widen
        assign ext = {{(OW-IW){stg[SW][IW-1]}}, stg[SW]};
    end else begin : g_narrow
        assign ext = stg[SW][OW-1:0];
    end

    assign dout = (code == '0) ? '0 : ext;
endmodule

// File: rtl/ec_tap_mac.sv
// One tap step: correct the coefficient, then multiply the corrected value by the current tap sample.
module ec_tap_mac #(
    parameter int DW = 16,
    parameter int CW = 32,
    parameter int SW = 4
) (
    input  logic signed [CW-1:0]    coef_in,
    input  logic signed [DW-1:0]    err_prev,
    input  logic signed [DW-1:0]    r_old,
    input  logic signed [DW-1:0]    r_cur,
    input  logic        [SW-1:0]    step,
    output logic signed [CW-1:0]    coef_out,
    output logic signed [CW+DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] grad;
    logic signed [CW-1:0] term;

    assign grad = err_prev * r_old;

    ec_step_shift #(.IW(PW), .OW(CW), .SW(SW)) i_shift (
        .din  (grad),
        .code (step),
        .dout (term)
    );

    assign coef_out = coef_in + term;
    assign prod     = coef_out * r_cur;
endmodule

// File: rtl/ec_saturate.sv
module ec_saturate #(
    parameter int IW = 56,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW-1:0] HI = IW'({1'b0, {(OW-1){1'b1}}});
    localparam logic signed [IW-1:0] LO = ~HI;

    always_comb begin
        if (din > HI)      dout = HI[OW-1:0];
        else if (din < LO) dout = LO[OW-1:0];
        else               dout = din[OW-1:0];
    end
endmodule

// File: rtl/lms_echo_canceller.sv
module lms_echo_canceller
    import ec_pkg::*;
#(
    parameter int N_TAPS = 128,
    parameter int DW     = 16,
    parameter int CW     = 32,
    parameter int FRAC   = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    output logic                    smp_ready,
    input  logic signed [DW-1:0]    smp_rx,
    input  logic signed [DW-1:0]    smp_tx,
    input  logic [SHIFT_CODE_W-1:0] mu_shift,
    output logic                    err_valid,
    input  logic                    err_ready,
    output logic signed [DW-1:0]    err_data
);
    localparam int SW   = SHIFT_CODE_W;
    localparam int KW   = (N_TAPS > 1) ? $clog2(N_TAPS) : 1;
    localparam int MW   = CW + DW;
    localparam int ACCW = MW + KW;
    localparam int LAST = N_TAPS - 1;

    typedef struct packed {
        ec_state_e                state;
        logic [KW-1:0]            k;
        logic signed [DW-1:0]     rx_new;
        logic signed [DW-1:0]     tx_new;
        logic [SW-1:0]            step;
        logic signed [ACCW-1:0]   acc;
        logic signed [DW-1:0]     err_prev;
        logic signed [DW-1:0]     err_out;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic signed [CW-1:0] coef_d [N_TAPS];
    logic signed [CW-1:0] coef_q [N_TAPS];
    logic signed [DW-1:0] hist_d [N_TAPS];
    logic signed [DW-1:0] hist_q [N_TAPS];

    // Tap operands for the current index
    logic signed [DW-1:0]   r_old;
    logic signed [DW-1:0]   r_cur;
    logic signed [CW-1:0]   coef_upd;
    logic signed [MW-1:0]   prod;
    logic signed [ACCW-1:0] acc_next;
    logic signed [ACCW-1:0] est;
    logic signed [ACCW:0]   diff;
    logic signed [DW-1:0]   err_sat;

    assign r_old = hist_q[c_q.k];
    assign r_cur = (c_q.k == '0) ? c_q.rx_new : hist_q[c_q.k - KW'(1)];

    ec_tap_mac #(.DW(DW), .CW(CW), .SW(SW)) i_mac (
        .coef_in  (coef_q[c_q.k]),
        .err_prev (c_q.err_prev),
        .r_old    (r_old),
        .r_cur    (r_cur),
        .step     (c_q.step),
        .coef_out (coef_upd),
        .prod     (prod)
    );

    assign acc_next = c_q.acc + {{KW{prod[MW-1]}}, prod};
    assign est      = acc_next >>> FRAC;
    assign diff     = {{(ACCW+1-DW){c_q.tx_new[DW-1]}}, c_q.tx_new} - {est[ACCW-1], est};

    ec_saturate #(.IW(ACCW+1), .OW(DW)) i_sat (
        .din  (diff),
        .dout (err_sat)
    );

    always_comb begin
        c_d    = c_q;
        coef_d = coef_q;
        hist_d = hist_q;
        unique case (c_q.state)
            ST_IDLE: begin
                if (smp_valid) begin
                    c_d.state  = ST_WALK;
                    c_d.k      = '0;
                    c_d.rx_new = smp_rx;
                    c_d.tx_new = smp_tx;
                    c_d.step   = mu_shift;
                    c_d.acc    = '0;
                end
            end
            ST_WALK: begin
                coef_d[c_q.k] = coef_upd;
                c_d.acc       = acc_next;
                if (c_q.k == KW'(LAST)) begin
                    c_d.err_out  = err_sat;
                    c_d.err_prev = err_sat;
                    c_d.state    = ST_DONE;
                    hist_d[0]    = c_q.rx_new;
                    for (int i = 1; i < N_TAPS; i++) begin
                        hist_d[i] = hist_q[i-1];
                    end
                end else begin
                    c_d.k = c_q.k + KW'(1);
                end
            end
            ST_DONE: begin
                if (err_ready) begin
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
            for (int i = 0; i < N_TAPS; i++) begin
                coef_q[i] <= '0;
                hist_q[i] <= '0;
            end
        end else begin
            c_q    <= c_d;
            coef_q <= coef_d;
            hist_q <= hist_d;
        end
    end

    assign smp_ready = (c_q.state == ST_IDLE);
    assign err_valid = (c_q.state == ST_DONE);
    assign err_data  = c_q.err_out;
endmodule

// File: rtl/ec_checker.sv
module ec_checker #(
    parameter int N_TAPS = 128,
    parameter int DW     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_valid,
    input logic                 smp_ready,
    input logic                 err_valid,
    input logic                 err_ready,
    input logic signed [DW-1:0] err_data
);
    // Cycles since the last acceptance edge, saturating
    logic [31:0] since_acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_acc_q <= '0;
        end else if (smp_valid && smp_ready) begin
            since_acc_q <= '0;
        end else if (since_acc_q != 32'hFFFF_FFFF) begin
            since_acc_q <= since_acc_q + 32'd1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (smp_ready && !err_valid));

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(smp_ready && err_valid));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_ready) |=> !smp_ready);

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(err_valid) |-> (since_acc_q == 32'(N_TAPS)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !err_ready) |=> (err_valid && $stable(err_data)));
endmodule

bind lms_echo_canceller ec_checker #(.N_TAPS(N_TAPS), .DW(DW)) i_ec_checker (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .err_valid (err_valid),
    .err_ready (err_ready),
    .err_data  (err_data)
);

// File: tb/test_lms_echo_canceller.sv
module test_lms_echo_canceller;
    localparam int N   = 128;
    localparam int DW  = 16;
    localparam int FR  = 15;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_valid = 1'b0;
    logic                 smp_ready;
    logic signed [DW-1:0] smp_rx = '0;
    logic signed [DW-1:0] smp_tx = '0;
    logic [3:0]           mu_shift = 4'd0;
    logic                 err_valid;
    logic                 err_ready = 1'b1;
    logic signed [DW-1:0] err_data;

    int n_total = 0;
    int n_fail  = 0;

    // Reference model state
    int      m_h [N];
    longint  m_r [N];
    longint  m_e;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    lms_echo_canceller i_lms_echo_canceller (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_rx    (smp_rx),
        .smp_tx    (smp_tx),
        .mu_shift  (mu_shift),
        .err_valid (err_valid),
        .err_ready (err_ready),
        .err_data  (err_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(input longint r, input longint d, input int s);
        longint acc = 0;
        longint term, rc, y, diff;
        for (int k = 0; k < N; k++) begin
            term = (s == 0) ? 64'sd0 : ((m_e * m_r[k]) >>> s);
            m_h[k] = int'(longint'(m_h[k]) + term);
            rc = (k == 0) ? r : m_r[k-1];
            acc += longint'(m_h[k]) * rc;
        end
        y = acc >>> FR;
        diff = d - y;
        if (diff > 32767) diff = 32767;
        if (diff < -32768) diff = -32768;
        for (int k = N - 1; k > 0; k--) m_r[k] = m_r[k-1];
        m_r[0] = r;
        m_e = diff;
        return diff;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        err_ready = 1'b1;
        for (int k = 0; k < N; k++) begin
            m_h[k] = 0;
            m_r[k] = 0;
        end
        m_e = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Offer one pair, optionally change the step code after acceptance,
    // optionally stall the consumer; returns the residual seen.
    task automatic send(input int r, input int d, input int s, input int s_late,
                        input bit stall, input string req, output longint got);
        longint exp;
        int idle;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_rx = DW'(r);
        smp_tx = DW'(d);
        mu_shift = 4'(s);
        while (!smp_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        if (s_late >= 0) mu_shift = 4'(s_late);
        if (stall) err_ready = 1'b0;
        exp = model_step(r, d, s);
        idle = 0;
        while (!err_valid && idle < 5000) begin
            idle++;
            @(negedge clk);
        end
        check(idle == N, "R3 latency", idle, N);
        got = err_data;
        if (stall) begin
            for (int c = 0; c < 12; c++) begin
                // offers during a pending result must be ignored (R2)
                smp_valid = 1'b1;
                smp_rx = 16'sh7FFF;
                smp_tx = -16'sh7000;
                @(negedge clk);
                if (!(err_valid && err_data == got && !smp_ready)) begin
                    check(1'b0, "R4 hold under stall", err_data, got);
                end
            end
            check(!smp_ready, "R2 busy while pending", smp_ready, 0);
            smp_valid = 1'b0;
            err_ready = 1'b1;
        end
        check(got == exp, req, got, exp);
        @(posedge clk);
        @(negedge clk);
        check(!err_valid && smp_ready, "R4 taken on handshake", err_valid, 0);
    endtask

    task automatic t_reset();
        longint g;
        do_reset();
        check(smp_ready == 1'b1, "R1 ready after reset", smp_ready, 1);
        check(err_valid == 1'b0, "R1 no result after reset", err_valid, 0);
        send(1000, 500, 4, -1, 1'b0, "R1 first residual equals line", g);
        check(g == 500, "R1 zero coefficients", g, 500);
    endtask

    task automatic t_adapt();
        longint g;
        int r, d;
        for (int i = 0; i < 24; i++) begin
            seed = seed * 1103515245 + 12345;
            r = int'((seed >> 16) % 4000) - 2000;
            d = r / 2 + int'((seed >> 4) % 64) - 32;
            send(r, d, 6, -1, 1'b0, "R5 R6 R11 adapting residual", g);
        end
    endtask

    task automatic t_codes();
        longint g;
        int codes [4] = '{1, 7, 12, 15};
        foreach (codes[j]) begin
            send(1500 - j * 700, 900, codes[j], -1, 1'b0, "R7 shift code", g);
            send(-800, 300 + j, codes[j], -1, 1'b0, "R7 shift code", g);
        end
    endtask

    task automatic t_freeze();
        longint g1, g2, g3;
        do_reset();
        send(1000, 300, 0, -1, 1'b0, "R8 halt first", g1);
        send(1000, 300, 0, -1, 1'b0, "R8 halt second", g2);
        check(g1 == 300 && g2 == 300, "R8 coefficients held", g2, 300);
        send(1000, 300, 1, -1, 1'b0, "R8 adapting again", g3);
        check(g3 != 300, "R8 nonzero code adapts", g3, 0);
    endtask

    task automatic t_late_code();
        longint g;
        send(2000, -1200, 3, 9, 1'b0, "R9 captured code", g);
        send(-1700, 800, 3, 0, 1'b0, "R9 captured code", g);
        send(600, 100, 5, -1, 1'b0, "R9 follow-up", g);
    endtask

    task automatic t_stall();
        longint g;
        send(1234, -321, 4, -1, 1'b1, "R2 R4 stalled result", g);
        send(-900, 450, 4, -1, 1'b0, "R2 junk offer ignored", g);
    endtask

    task automatic t_saturate();
        longint g;
        do_reset();
        send(20000, 20000, 1, -1, 1'b0, "R10 build up", g);
        send(20000, -32768, 1, -1, 1'b0, "R10 low clip model", g);
        check(g == -32768, "R10 clips low", g, -32768);
        send(0, 0, 1, -1, 1'b0, "R10 high clip model", g);
        check(g == 32767, "R10 clips high from stored clipped error", g, 32767);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        t_reset();
        t_adapt();
        t_codes();
        t_late_code();
        t_stall();
        t_freeze();
        t_saturate();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule